// File: doc/BRIEF.md
# Highest Priority Pending Interrupt Selector

This block sits beside the interrupt state storage of a multi-processor interrupt controller. For every processor lane it looks at all interrupt sources, keeps those that are both enabled and pending for that lane, and picks the one with the numerically smallest priority value. A smaller value means more urgent. The winner is then tested against the lane's priority mask and against the priority of the interrupt the processor is already servicing. From the result the block drives the lane's interrupt request line and a pending-ID readback value.

Sources with an index below `NUM_BANKED` carry a separate priority for each processor. Higher-numbered sources share one priority across all processors. ID 1023 is reserved and means "nothing to report". A running priority of 0x100 stands for an idle processor. Because it is larger than every 8-bit priority, any winner that passes the mask can then raise a request.

Each lane holds a registered decision state. The next state is computed combinationally from the inputs, so the outputs follow any input change one clock later. There are four states:
- `ST_OFF`: the distributor or the lane is disabled.
- `ST_NONE`: no source qualifies, or the winner is masked.
- `ST_HELD`: the winner is published, but it does not beat the running priority.
- `ST_SIGNAL`: the winner is published and the request is raised.

Every state can move to any other state in one clock. The transition depends only on the current inputs, checked in this order: enables first, then winner and mask, then running priority.

Top module: `hp_pend_select`

## Requirements
- R1: Among sources whose enable bit is 1 and whose pending bit for the lane is 1, the source with the smallest priority value wins. A disabled or non-pending source never wins.
- R2: When several qualifying sources share the smallest priority value, the lowest-numbered one wins.
- R3: When `dist_en_i` is 0, or the lane's bit in `lane_en_i` is 0, that lane's `irq_o` bit is 0 and its ID field reads 1023.
- R4: A winner whose priority is greater than the lane's mask gives ID 1023 and no request. A priority equal to the mask passes.
- R5: The request is 1 only when the winner's priority is strictly less than the lane's running priority. When the priority is equal or greater, the ID is still published and the request stays 0.
- R6: A running priority of 0x100 lets a winner of priority 0xFF raise the request when the mask is 0xFF.
- R7: Source s < `NUM_BANKED` takes lane c's priority from `prio_bank_i[(c*NUM_BANKED+s)*8 +: 8]`. Source s >= `NUM_BANKED` takes `prio_shared_i[(s-NUM_BANKED)*8 +: 8]` for every lane.
- R8: During reset every `irq_o` bit is 0 and every ID field reads 1023. After reset, both outputs reflect the inputs sampled at the previous rising clock edge and hold their values between edges.
- R9: Pending bits are per lane: `pend_i[c*NUM_SRC+s]` affects lane c only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dist_en_i | input | 1 | Global distributor enable |
| lane_en_i | input | NUM_CPU | Per-processor interface enable, bit c for lane c |
| src_en_i | input | NUM_SRC | Per-source enable, bit s for source s |
| pend_i | input | NUM_CPU*NUM_SRC | Pending bit for lane c, source s at index c*NUM_SRC+s |
| prio_bank_i | input | NUM_CPU*NUM_BANKED*PRIO_W | Per-lane priorities of the banked sources |
| prio_shared_i | input | (NUM_SRC-NUM_BANKED)*PRIO_W | Shared priorities of the remaining sources |
| mask_i | input | NUM_CPU*PRIO_W | Priority mask of lane c at c*PRIO_W |
| run_prio_i | input | NUM_CPU*(PRIO_W+1) | Running priority of lane c at c*(PRIO_W+1); 0x100 means idle |
| irq_o | output | NUM_CPU | Registered interrupt request, bit c for lane c |
| pend_id_o | output | NUM_CPU*10 | Registered highest-pending ID of lane c at c*10; 1023 means none |

## Verification
The hardest state to reach is `ST_HELD`. It needs a winner that passes the mask but does not strictly beat the running priority. The stimulus therefore walks the running priority of one lane down to exactly the winner's value, and then to one above it, so that the boundary between holding and signalling is crossed in both directions. Banked and shared sources are exercised with different per-lane priorities on the same sources, so that each lane must pick a different winner from the same pending set.

// File: rtl/hps_pkg.sv
package hps_pkg;
    localparam int ID_W = 10;
    localparam logic [ID_W-1:0] NO_IRQ_ID = 10'd1023;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_NONE   = 2'd1,
        ST_HELD   = 2'd2,
        ST_SIGNAL = 2'd3
    } lane_state_e;
endpackage

// File: rtl/hps_scan.sv
module hps_scan
    import hps_pkg::*;
#(
    parameter int NUM_SRC = 40,
    parameter int PRIO_W  = 8
) (
    input  logic [NUM_SRC-1:0]        en_i,
    input  logic [NUM_SRC-1:0]        pend_i,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
    output logic                      found_o,
    output logic [PRIO_W-1:0]         win_prio_o,
    output logic [ID_W-1:0]           win_id_o
);
    // Linear scan: replace the candidate only on a strictly smaller value,
    // so the lowest index wins a tie.
    always_comb begin
        found_o    = 1'b0;
        win_prio_o = '1;
        win_id_o   = NO_IRQ_ID;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (en_i[s] && pend_i[s] &&
                (!found_o || (prio_i[s*PRIO_W +: PRIO_W] < win_prio_o))) begin
                found_o    = 1'b1;
                win_prio_o = prio_i[s*PRIO_W +: PRIO_W];
                win_id_o   = ID_W'(s);
            end
        end
    end
endmodule

// File: rtl/hps_lane.sv
module hps_lane
    import hps_pkg::*;
#(
    parameter int PRIO_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              dist_en_i,
    input  logic              lane_en_i,
    input  logic              found_i,
    input  logic [PRIO_W-1:0] win_prio_i,
    input  logic [ID_W-1:0]   win_id_i,
    input  logic [PRIO_W-1:0] mask_i,
    input  logic [PRIO_W:0]   run_prio_i,
    output logic              irq_o,
    output logic [ID_W-1:0]   id_o
);
    lane_state_e state_d, state_q;
    logic [ID_W-1:0] id_d, id_q;

    always_comb begin
        if (!(dist_en_i && lane_en_i)) begin
            state_d = ST_OFF;
        end else if (!found_i || (win_prio_i > mask_i)) begin
            state_d = ST_NONE;
        end else if ({1'b0, win_prio_i} < run_prio_i) begin
            state_d = ST_SIGNAL;
        end else begin
            state_d = ST_HELD;
        end
        id_d = win_id_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_OFF;
            id_q    <= NO_IRQ_ID;
        end else begin
            state_q <= state_d;
            id_q    <= id_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_OFF, ST_NONE: begin
                irq_o = 1'b0;
                id_o  = NO_IRQ_ID;
            end
            ST_HELD: begin
                irq_o = 1'b0;
                id_o  = id_q;
            end
            ST_SIGNAL: begin
                irq_o = 1'b1;
                id_o  = id_q;
            end
            default: begin
                irq_o = 1'b0;
                id_o  = NO_IRQ_ID;
            end
        endcase
    end

    assert_off_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(dist_en_i && lane_en_i) |=> (!irq_o && id_o == NO_IRQ_ID));

    assert_masked_none_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dist_en_i && lane_en_i && found_i && win_prio_i > mask_i)
            |=> (!irq_o && id_o == NO_IRQ_ID));

    assert_held_no_irq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dist_en_i && lane_en_i && found_i && win_prio_i <= mask_i &&
         {1'b0, win_prio_i} >= run_prio_i)
            |=> (!irq_o && id_o == $past(win_id_i)));

    assert_signal_raised_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dist_en_i && lane_en_i && found_i && win_prio_i <= mask_i &&
         {1'b0, win_prio_i} < run_prio_i)
            |=> (irq_o && id_o == $past(win_id_i)));

    assert_irq_has_id_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (id_o != NO_IRQ_ID));
endmodule

// File: rtl/hp_pend_select.sv
module hp_pend_select
    import hps_pkg::*;
#(
    parameter int NUM_SRC    = 40,
    parameter int NUM_BANKED = 32,
    parameter int NUM_CPU    = 2,
    parameter int PRIO_W     = 8
) (
    input  logic                                 clk_i,
    input  logic                                 rst_ni,
    input  logic                                 dist_en_i,
    input  logic [NUM_CPU-1:0]                   lane_en_i,
    input  logic [NUM_SRC-1:0]                   src_en_i,
    input  logic [NUM_CPU*NUM_SRC-1:0]           pend_i,
    input  logic [NUM_CPU*NUM_BANKED*PRIO_W-1:0] prio_bank_i,
    input  logic [(NUM_SRC-NUM_BANKED)*PRIO_W-1:0] prio_shared_i,
    input  logic [NUM_CPU*PRIO_W-1:0]            mask_i,
    input  logic [NUM_CPU*(PRIO_W+1)-1:0]        run_prio_i,
    output logic [NUM_CPU-1:0]                   irq_o,
    output logic [NUM_CPU*ID_W-1:0]              pend_id_o
);
    localparam int PRIO_VIEW_W = NUM_SRC * PRIO_W;
    localparam int RUN_W       = PRIO_W + 1;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_lane
        logic [PRIO_VIEW_W-1:0] prio_view;
        logic                   found;
        logic [PRIO_W-1:0]      win_prio;
        logic [ID_W-1:0]        win_id;

        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            if (s < NUM_BANKED) begin : g_banked
                assign prio_view[s*PRIO_W +: PRIO_W] =
                    prio_bank_i[(c*NUM_BANKED+s)*PRIO_W +: PRIO_W];
            end else begin : g_shared
                assign prio_view[s*PRIO_W +: PRIO_W] =
                    prio_shared_i[(s-NUM_BANKED)*PRIO_W +: PRIO_W];
            end
        end

        hps_scan #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_scan (
            .en_i      (src_en_i),
            .pend_i    (pend_i[c*NUM_SRC +: NUM_SRC]),
            .prio_i    (prio_view),
            .found_o   (found),
            .win_prio_o(win_prio),
            .win_id_o  (win_id)
        );

        hps_lane #(.PRIO_W(PRIO_W)) u_lane (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .dist_en_i (dist_en_i),
            .lane_en_i (lane_en_i[c]),
            .found_i   (found),
            .win_prio_i(win_prio),
            .win_id_i  (win_id),
            .mask_i    (mask_i[c*PRIO_W +: PRIO_W]),
            .run_prio_i(run_prio_i[c*RUN_W +: RUN_W]),
            .irq_o     (irq_o[c]),
            .id_o      (pend_id_o[c*ID_W +: ID_W])
        );
    end
endmodule

// File: tb/hp_pend_select_test.sv
module hp_pend_select_test;
    localparam int NS = 40, NB = 32, NC = 2, PW = 8, IW = 10;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    always #4 clk = ~clk;

    logic                     d_dist, s_dist;
    logic [NC-1:0]            d_lane, s_lane;
    logic [NS-1:0]            d_en, s_en;
    logic [NC*NS-1:0]         d_pend, s_pend;
    logic [NC*NB*PW-1:0]      d_bank, s_bank;
    logic [(NS-NB)*PW-1:0]    d_shared, s_shared;
    logic [NC*PW-1:0]         d_mask, s_mask;
    logic [NC*(PW+1)-1:0]     d_run, s_run;
    logic [NC-1:0]            irq;
    logic [NC*IW-1:0]         pid;

    hp_pend_select #(.NUM_SRC(NS), .NUM_BANKED(NB), .NUM_CPU(NC), .PRIO_W(PW)) uut (
        .clk_i(clk), .rst_ni(rst_ni), .dist_en_i(d_dist), .lane_en_i(d_lane),
        .src_en_i(d_en), .pend_i(d_pend), .prio_bank_i(d_bank),
        .prio_shared_i(d_shared), .mask_i(d_mask), .run_prio_i(d_run),
        .irq_o(irq), .pend_id_o(pid)
    );

    typedef struct {
        int          due;
        int          cpu;
        logic        irq;
        logic [IW-1:0] id;
        string       tag;
    } exp_t;
    exp_t q[$];

    int cyc = 0, errors = 0, checks = 0;
    logic          prev_irq [NC];
    logic [IW-1:0] prev_id  [NC];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic void model(input int c, output logic ei, output logic [IW-1:0] eid);
        logic [PW:0] best;
        logic [PW-1:0] p;
        int wid;
        best = 9'h100;
        wid  = -1;
        for (int i = 0; i < NS; i++) begin
            if (i < NB) p = s_bank[(c*NB+i)*PW +: PW];
            else        p = s_shared[(i-NB)*PW +: PW];
            if (s_en[i] && s_pend[c*NS+i] && ({1'b0, p} < best)) begin
                best = {1'b0, p};
                wid  = i;
            end
        end
        ei  = 1'b0;
        eid = 10'd1023;
        if (s_dist && s_lane[c] && wid >= 0 && best <= {1'b0, s_mask[c*PW +: PW]}) begin
            eid = IW'(wid);
            ei  = best < s_run[c*(PW+1) +: PW+1];
        end
    endfunction

    task automatic apply();
        d_dist = s_dist; d_lane = s_lane; d_en = s_en; d_pend = s_pend;
        d_bank = s_bank; d_shared = s_shared; d_mask = s_mask; d_run = s_run;
    endtask

    // Driver: applies staged inputs at a falling edge and queues expectations.
    task automatic step(input string tag);
        logic ei;
        logic [IW-1:0] eid;
        @(negedge clk);
        apply();
        for (int c = 0; c < NC; c++) begin
            model(c, ei, eid);
            q.push_back('{due: cyc + 1, cpu: c, irq: ei, id: eid, tag: tag});
        end
        #1;
        for (int c = 0; c < NC; c++) begin
            checks++;
            if (irq[c] !== prev_irq[c] || pid[c*IW +: IW] !== prev_id[c]) begin
                errors++;
                $display("FAIL R8 hold before edge (%s) cpu%0d: irq=%0b id=%0d expected irq=%0b id=%0d",
                         tag, c, irq[c], pid[c*IW +: IW], prev_irq[c], prev_id[c]);
            end
            model(c, ei, eid);
            prev_irq[c] = ei;
            prev_id[c]  = eid;
        end
    endtask

    // Monitor: pops due expectations and compares them with the outputs.
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0 && q[0].due == cyc) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (irq[e.cpu] !== e.irq || pid[e.cpu*IW +: IW] !== e.id) begin
                    errors++;
                    $display("FAIL %s cpu%0d: irq=%0b id=%0d expected irq=%0b id=%0d",
                             e.tag, e.cpu, irq[e.cpu], pid[e.cpu*IW +: IW], e.irq, e.id);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        s_dist = 1'b0; s_lane = '0; s_en = '0; s_pend = '0;
        s_bank = '0; s_shared = '0;
        s_mask = {8'hF0, 8'hF0};
        s_run  = {9'h100, 9'h100};
        apply();
        for (int c = 0; c < NC; c++) begin
            prev_irq[c] = 1'b0;
            prev_id[c]  = 10'd1023;
        end
        repeat (3) @(negedge clk);
        for (int c = 0; c < NC; c++) begin
            checks++;
            if (irq[c] !== 1'b0 || pid[c*IW +: IW] !== 10'd1023) begin
                errors++;
                $display("FAIL R8 reset state cpu%0d: irq=%0b id=%0d expected irq=0 id=1023",
                         c, irq[c], pid[c*IW +: IW]);
            end
        end
        rst_ni = 1'b1;

        s_dist = 1'b1; s_lane = '1;
        step("R3 enables on, nothing pending");

        s_en[5] = 1'b1; s_pend[0*NS+5] = 1'b1; s_bank[(0*NB+5)*PW +: PW] = 8'h40;
        step("R1 single source on cpu0, R9 cpu1 unaffected");

        s_en[7] = 1'b1; s_pend[0*NS+7] = 1'b1; s_bank[(0*NB+7)*PW +: PW] = 8'h20;
        step("R1 smaller value wins");

        s_en[7] = 1'b0;
        step("R1 disabled source ignored");

        s_en[3] = 1'b1; s_pend[0*NS+3] = 1'b1; s_bank[(0*NB+3)*PW +: PW] = 8'h40;
        step("R2 tie goes to lowest number");

        s_mask[0*PW +: PW] = 8'h3F;
        step("R4 winner above mask");

        s_mask[0*PW +: PW] = 8'h40;
        step("R4 winner equal to mask passes");

        s_run[0*(PW+1) +: PW+1] = 9'h040;
        step("R5 equal running priority holds");

        s_run[0*(PW+1) +: PW+1] = 9'h041;
        step("R5 strictly below running signals");

        s_run[0*(PW+1) +: PW+1] = 9'h100; s_mask[0*PW +: PW] = 8'hFF;
        s_pend[0*NS+3] = 1'b0; s_pend[0*NS+5] = 1'b0;
        s_en[10] = 1'b1; s_pend[0*NS+10] = 1'b1; s_bank[(0*NB+10)*PW +: PW] = 8'hFF;
        step("R6 idle running lets priority 0xFF signal");

        s_en[35] = 1'b1; s_shared[(35-NB)*PW +: PW] = 8'h10;
        s_pend[0*NS+35] = 1'b1; s_pend[1*NS+35] = 1'b1;
        step("R7 shared priority on both lanes");

        s_en[2] = 1'b1;
        s_bank[(0*NB+2)*PW +: PW] = 8'h08; s_bank[(1*NB+2)*PW +: PW] = 8'h80;
        s_pend[0*NS+2] = 1'b1; s_pend[1*NS+2] = 1'b1;
        step("R7 banked priority differs per lane");

        s_dist = 1'b0;
        step("R3 distributor disabled");

        s_dist = 1'b1; s_lane[1] = 1'b0;
        step("R3 lane 1 disabled");

        s_lane[1] = 1'b1; s_pend[1*NS+35] = 1'b0;
        step("R9 pending cleared on lane 1 only");

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule